// File: doc/BRIEF.md
# NAND Page Operation Sequencer

This block frames the bus cycles that a 16-bit NAND device with 2 KiB pages needs for three operations: reading a page, programming a page and erasing a block. A request carries an operation code, a block index and a page index. The sequencer then issues a command strobe, a burst of address strobes, optional data words, a confirm command and a status-poll loop, each strobe lasting one clock with its byte on a shared byte bus. Pin-level timing and ECC generation sit outside; this block only orders and frames the cycles.

Page data moves through two word streams with valid/ready handshakes: words to be programmed come in on the input stream and words read from the device leave on the output stream. A stalled producer or consumer simply holds the sequencer in its data phase. When an operation ends, a one-cycle done pulse carries a two-bit result code.

Top module: `nand_page_seq`

## Requirements
- R1: While reset is asserted and right after it, no strobe is active, done_o is low, in_ready_o is low and out_valid_o is low.
- R2: A read (op_i = 0) issues command 0x00, five address cycles, command 0x30, the status poll of R6, then command 0x00 again, and then delivers 1056 words (1024 main plus 32 spare) on the output stream in device order.
- R3: With A = block << 17 | page << 11 (block 11 bits, page 6 bits), the five address bytes of read and program are, in order, A[7:0], A[10:8], A[18:11], A[26:19], A[27].
- R4: A program (op_i = 1) issues command 0x80, the five address cycles of R3, writes 1056 words taken from the input stream in order, then issues command 0x10 and the status poll of R6.
- R5: An erase (op_i = 2) issues command 0x60, three address bytes A[18:11], A[26:19], A[34:27] (upper bits zero), then command 0xD0 and the status poll of R6; no data words move.
- R6: Each status attempt is command 0x70 followed by one device read; bit 6 of the read word set means ready, otherwise the attempt is repeated.
- R7: Result codes are 0 ok, 1 timeout, 2 fail. After 1500 attempts without ready the result is timeout and a read moves no data; a ready status on attempt 1500 still succeeds. Program and erase report fail when bit 0 of the ready status is set; a read ignores bit 0.
- R8: done_o is a single-cycle pulse raised once per accepted operation when it ends, with result_o valid in that cycle.
- R9: A request arriving while an operation is in progress is ignored and does not alter the running cycle sequence.
- R10: The output word stays valid and unchanged while out_ready_i is low, and no device read is issued while it waits; a program issues no write strobe while in_valid_i is low. No word is lost or duplicated.
- R11: op_i = 3 is not an operation: a request with it produces no strobe and no done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Operation request, taken only when idle |
| op_i | input | 2 | 0 read, 1 program, 2 erase, 3 none |
| blk_i | input | BLK_W | Block index |
| page_i | input | PG_W | Page index within the block |
| done_o | output | 1 | One-cycle end-of-operation pulse |
| result_o | output | 2 | 0 ok, 1 timeout, 2 fail; valid with done_o |
| dev_cle_o | output | 1 | Command cycle strobe |
| dev_ale_o | output | 1 | Address cycle strobe |
| dev_byte_o | output | 8 | Command or address byte |
| dev_wr_o | output | 1 | Data word write strobe |
| dev_wd_o | output | 16 | Data word to the device |
| dev_re_o | output | 1 | Data word read strobe |
| dev_rd_i | input | 16 | Word returned by the device in the read strobe cycle |
| in_valid_i | input | 1 | Program data word valid |
| in_data_i | input | 16 | Program data word |
| in_ready_o | output | 1 | Sequencer takes program data |
| out_valid_o | output | 1 | Read data word valid |
| out_data_o | output | 16 | Read data word |
| out_ready_i | input | 1 | Consumer takes read data |

## Verification
The assertions watch every cycle for the properties that hold regardless of scenario: at most one device strobe at a time, every address burst opened by a command, done lasting one cycle with a legal result code, the read word held stable under backpressure, and the poll counter staying inside its bound. Only the bench scenarios can show that the byte values and their order match the address split, that the poll loop stops exactly at the 1500th attempt, that fail decoding differs between read and program or erase, and that requests during an operation or with the unused code leave the cycle trace untouched.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  typedef enum logic [1:0] {OP_READ = 2'd0, OP_PROG = 2'd1, OP_ERASE = 2'd2, OP_NOP = 2'd3} op_e;
  typedef enum logic [1:0] {RES_OK = 2'd0, RES_TMO = 2'd1, RES_FAIL = 2'd2} res_e;
  typedef enum logic [3:0] {
    S_IDLE, S_CMD, S_ADDR, S_WDATA, S_CONF, S_SCMD, S_SRD, S_RCMD, S_RDATA
  } st_e;

  localparam logic [7:0] C_READ     = 8'h00;
  localparam logic [7:0] C_READ_GO  = 8'h30;
  localparam logic [7:0] C_PROG     = 8'h80;
  localparam logic [7:0] C_PROG_GO  = 8'h10;
  localparam logic [7:0] C_ERASE    = 8'h60;
  localparam logic [7:0] C_ERASE_GO = 8'hD0;
  localparam logic [7:0] C_STAT     = 8'h70;

  localparam int RDY_BIT  = 6;
  localparam int FAIL_BIT = 0;
endpackage

// File: rtl/nand_addr_fmt.sv
module nand_addr_fmt #(
  parameter int BLK_W = 11,
  parameter int PG_W  = 6,
  parameter int COL_W = 11
) (
  input  logic [BLK_W-1:0] blk_i,
  input  logic [PG_W-1:0]  pg_i,
  input  logic [2:0]       idx_i,
  input  logic             erase_i,
  output logic [7:0]       byte_o
);
  localparam int RAW_W = 35;

  logic [RAW_W-1:0] raw;

  always_comb begin
    raw = (RAW_W'(blk_i) << (COL_W + PG_W)) | (RAW_W'(pg_i) << COL_W);
    if (erase_i) begin
      // row bytes only, column dropped
      case (idx_i)
        3'd0:    byte_o = raw[18:11];
        3'd1:    byte_o = raw[26:19];
        default: byte_o = raw[34:27];
      endcase
    end else begin
      case (idx_i)
        3'd0:    byte_o = raw[7:0];
        3'd1:    byte_o = {5'b0, raw[10:8]};
        3'd2:    byte_o = raw[18:11];
        3'd3:    byte_o = raw[26:19];
        default: byte_o = {7'b0, raw[27]};
      endcase
    end
  end
endmodule

// File: rtl/nand_seq_cnt.sv
module nand_seq_cnt #(
  parameter int LIMIT = 4,
  localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  logic [W-1:0] cnt_q;

  assign last_o = (cnt_q == W'(LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= last_o ? '0 : cnt_q + W'(1);
  end

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= W'(LIMIT - 1)); // R7
endmodule

// File: rtl/nand_page_seq.sv
module nand_page_seq
  import nand_seq_pkg::*;
#(
  parameter int BLK_W       = 11,
  parameter int PG_W        = 6,
  parameter int COL_W       = 11,
  parameter int MAIN_WORDS  = 1024,
  parameter int SPARE_WORDS = 32,
  parameter int MAX_POLL    = 1500
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [1:0]       op_i,
  input  logic [BLK_W-1:0] blk_i,
  input  logic [PG_W-1:0]  page_i,
  output logic             done_o,
  output logic [1:0]       result_o,
  output logic             dev_cle_o,
  output logic             dev_ale_o,
  output logic [7:0]       dev_byte_o,
  output logic             dev_wr_o,
  output logic [15:0]      dev_wd_o,
  output logic             dev_re_o,
  input  logic [15:0]      dev_rd_i,
  input  logic             in_valid_i,
  input  logic [15:0]      in_data_i,
  output logic             in_ready_o,
  output logic             out_valid_o,
  output logic [15:0]      out_data_o,
  input  logic             out_ready_i
);
  localparam int PAGE_WORDS = MAIN_WORDS + SPARE_WORDS;

  st_e              st_q;
  op_e              op_q;
  res_e             res_q;
  logic [BLK_W-1:0] blk_q;
  logic [PG_W-1:0]  pg_q;
  logic [2:0]       aidx_q;
  logic             done_q;
  logic             out_vld_q;
  logic [15:0]      out_dat_q;

  logic       fire_rd, rdy, word_last, poll_last;
  logic [2:0] aidx_last;
  logic [7:0] cmd_b, addr_b;

  assign rdy       = dev_rd_i[RDY_BIT];
  assign fire_rd   = (st_q == S_RDATA) && (!out_vld_q || out_ready_i);
  assign aidx_last = (op_q == OP_ERASE) ? 3'd2 : 3'd4;

  assign in_ready_o  = (st_q == S_WDATA);
  assign dev_wr_o    = in_ready_o && in_valid_i;
  assign dev_wd_o    = in_data_i;
  assign dev_re_o    = (st_q == S_SRD) || fire_rd;
  assign dev_ale_o   = (st_q == S_ADDR);
  assign dev_cle_o   = (st_q == S_CMD) || (st_q == S_CONF) || (st_q == S_SCMD) || (st_q == S_RCMD);
  assign dev_byte_o  = dev_cle_o ? cmd_b : (dev_ale_o ? addr_b : 8'h00);
  assign done_o      = done_q;
  assign result_o    = res_q;
  assign out_valid_o = out_vld_q;
  assign out_data_o  = out_dat_q;

  always_comb begin
    case (st_q)
      S_CMD:   cmd_b = (op_q == OP_READ) ? C_READ : ((op_q == OP_PROG) ? C_PROG : C_ERASE);
      S_CONF:  cmd_b = (op_q == OP_READ) ? C_READ_GO : ((op_q == OP_PROG) ? C_PROG_GO : C_ERASE_GO);
      S_RCMD:  cmd_b = C_READ;
      default: cmd_b = C_STAT;
    endcase
  end

  nand_addr_fmt #(.BLK_W(BLK_W), .PG_W(PG_W), .COL_W(COL_W)) u_addr (
    .blk_i   (blk_q),
    .pg_i    (pg_q),
    .idx_i   (aidx_q),
    .erase_i (op_q == OP_ERASE),
    .byte_o  (addr_b)
  );

  // shared by program and read data phases
  nand_seq_cnt #(.LIMIT(PAGE_WORDS)) u_words (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (st_q == S_IDLE),
    .inc_i  (dev_wr_o || fire_rd),
    .last_o (word_last)
  );

  nand_seq_cnt #(.LIMIT(MAX_POLL)) u_poll (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (st_q == S_CONF),
    .inc_i  ((st_q == S_SRD) && !rdy),
    .last_o (poll_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      op_q   <= OP_READ;
      res_q  <= RES_OK;
      blk_q  <= '0;
      pg_q   <= '0;
      aidx_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        S_IDLE: if (req_i && (op_e'(op_i) != OP_NOP)) begin
          op_q  <= op_e'(op_i);
          blk_q <= blk_i;
          pg_q  <= page_i;
          st_q  <= S_CMD;
        end
        S_CMD: begin
          aidx_q <= '0;
          st_q   <= S_ADDR;
        end
        S_ADDR: begin
          if (aidx_q == aidx_last) st_q <= (op_q == OP_PROG) ? S_WDATA : S_CONF;
          else                     aidx_q <= aidx_q + 3'd1;
        end
        S_WDATA: if (dev_wr_o && word_last) st_q <= S_CONF;
        S_CONF:  st_q <= S_SCMD;
        S_SCMD:  st_q <= S_SRD;
        S_SRD: begin
          if (rdy) begin
            if (op_q == OP_READ) begin
              st_q <= S_RCMD;
            end else begin
              st_q   <= S_IDLE;
              done_q <= 1'b1;
              res_q  <= dev_rd_i[FAIL_BIT] ? RES_FAIL : RES_OK;
            end
          end else if (poll_last) begin
            st_q   <= S_IDLE;
            done_q <= 1'b1;
            res_q  <= RES_TMO;
          end else begin
            st_q <= S_SCMD;
          end
        end
        S_RCMD: st_q <= S_RDATA;
        S_RDATA: if (fire_rd && word_last) begin
          st_q   <= S_IDLE;
          done_q <= 1'b1;
          res_q  <= RES_OK;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_vld_q <= 1'b0;
      out_dat_q <= '0;
    end else if (fire_rd) begin
      out_vld_q <= 1'b1;
      out_dat_q <= dev_rd_i;
    end else if (out_ready_i) begin
      out_vld_q <= 1'b0;
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dev_cle_o, dev_ale_o, dev_wr_o, dev_re_o})); // R2
  AST_ADDR_AFTER_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dev_ale_o) |-> $past(dev_cle_o)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_RESULT_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (result_o != 2'd3)); // R7
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o))); // R10
endmodule

// File: tb/nand_page_seq_test.sv
module nand_page_seq_test;
  localparam int CLK_P  = 10;
  localparam int NWORDS = 1056;
  localparam int MAXP   = 1500;
  localparam int TR_SZ  = 8192;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_P / 2) clk = ~clk;

  logic        req = 1'b0;
  logic [1:0]  op_in = 2'd0;
  logic [10:0] blk_in = '0;
  logic [5:0]  pg_in = '0;
  logic        done;
  logic [1:0]  result;
  logic        dev_cle, dev_ale, dev_wr, dev_re;
  logic [7:0]  dev_byte;
  logic [15:0] dev_wd, dev_rd;
  logic        in_valid, in_ready, out_valid, out_ready;
  logic [15:0] in_data, out_data;

  nand_page_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .op_i(op_in), .blk_i(blk_in), .page_i(pg_in),
    .done_o(done), .result_o(result),
    .dev_cle_o(dev_cle), .dev_ale_o(dev_ale), .dev_byte_o(dev_byte),
    .dev_wr_o(dev_wr), .dev_wd_o(dev_wd), .dev_re_o(dev_re), .dev_rd_i(dev_rd),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_ready_o(in_ready),
    .out_valid_o(out_valid), .out_data_o(out_data), .out_ready_i(out_ready)
  );

  int checks = 0;
  int fails  = 0;

  int          cfg_busy = 0;
  logic        cfg_fail = 1'b0;
  logic [15:0] cfg_seed = 16'h0;

  function automatic logic [15:0] pat(logic [15:0] s, int i);
    return s ^ 16'(i * 40503 + 4660);
  endfunction

  // device model
  logic [7:0] last_cmd = 8'hFF;
  int         busy_left = 0;
  int         rd_idx = 0;

  assign dev_rd = (last_cmd == 8'h70)
                ? ((busy_left > 0) ? 16'h0001 : {9'b0, 1'b1, 5'b0, cfg_fail})
                : pat(cfg_seed ^ 16'hA5A5, rd_idx);

  always @(posedge clk) begin
    if (dev_cle) begin
      last_cmd <= dev_byte;
      if (dev_byte == 8'h30 || dev_byte == 8'h10 || dev_byte == 8'hD0) busy_left <= cfg_busy;
      if (dev_byte == 8'h00) rd_idx <= 0;
    end
    if (dev_re && last_cmd == 8'h70 && busy_left > 0) busy_left <= busy_left - 1;
    else if (dev_re && last_cmd != 8'h70) rd_idx <= rd_idx + 1;
  end

  // stream drivers and cycle trace
  logic [9:0] tr [TR_SZ];
  int tr_n = 0;
  int wr_cnt = 0, wr_bad = 0, rd_cnt = 0, rd_bad = 0, rd_loc = 0;
  int done_cnt = 0;
  logic took = 1'b0;

  initial begin
    in_valid = 1'b0;
    in_data = '0;
    out_ready = 1'b0;
    forever begin
      @(negedge clk);
      if (took || !in_valid || !in_ready) begin
        in_valid = ($urandom % 4) != 0;
        in_data  = pat(cfg_seed, wr_cnt);
      end
      out_ready = ($urandom % 4) != 0;
      #1;
      took = 1'b0;
      if (done) done_cnt++;
      if (dev_cle && tr_n < TR_SZ) begin
        tr[tr_n] = {2'd1, dev_byte};
        tr_n++;
        if (dev_byte == 8'h30) rd_loc = 0;
      end
      if (dev_ale && tr_n < TR_SZ) begin
        tr[tr_n] = {2'd2, dev_byte};
        tr_n++;
      end
      if (dev_wr) begin
        if (dev_wd !== pat(cfg_seed, wr_cnt)) wr_bad++;
        wr_cnt++;
        took = 1'b1;
      end
      if (out_valid && out_ready) begin
        if (out_data !== pat(cfg_seed ^ 16'hA5A5, rd_loc)) rd_bad++;
        rd_loc++;
        rd_cnt++;
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  int ex_base, ex_n;
  bit ex_ok;

  task automatic exp_entry(input logic [9:0] v);
    if (ex_base + ex_n >= tr_n || tr[ex_base + ex_n] !== v) ex_ok = 0;
    ex_n++;
  endtask

  task automatic run_op(input int op, input int blk, input int pg, input int busy,
                        input bit fail, input bit poke);
    int t0, w0, r0, wb0, rb0, d0, cyc, np, ex_res;
    logic [1:0] res;
    bit seen;
    longint a;
    string rq;
    cfg_busy = busy;
    cfg_fail = fail;
    cfg_seed = 16'($urandom);
    t0 = tr_n; w0 = wr_cnt; r0 = rd_cnt; wb0 = wr_bad; rb0 = rd_bad; d0 = done_cnt;
    req = 1'b1; op_in = 2'(op); blk_in = 11'(blk); pg_in = 6'(pg);
    @(negedge clk);
    req = 1'b0;
    seen = 0; cyc = 0; res = 2'd3;
    while (!seen && cyc < 8000) begin
      @(negedge clk); #2;
      cyc++;
      if (poke && cyc == 40) begin req = 1'b1; op_in = 2'd2; blk_in = 11'd7; end
      else req = 1'b0;
      if (done) begin seen = 1; res = result; end
    end
    req = 1'b0;
    for (int k = 0; k < 200 && out_valid; k++) @(negedge clk);
    repeat (3) @(negedge clk);

    ex_res = (busy >= MAXP) ? 1 : ((op != 0 && fail) ? 2 : 0);
    chk(seen && res == 2'(ex_res), "R7 R8", "result code", res, ex_res);
    chk(done_cnt - d0 == 1, "R8", "done pulses", done_cnt - d0, 1);

    ex_base = t0; ex_n = 0; ex_ok = 1;
    a = (longint'(blk) << 17) | (longint'(pg) << 11);
    exp_entry({2'd1, (op == 0) ? 8'h00 : ((op == 1) ? 8'h80 : 8'h60)});
    if (op == 2) begin
      exp_entry({2'd2, 8'((a >> 11) & 255)});
      exp_entry({2'd2, 8'((a >> 19) & 255)});
      exp_entry({2'd2, 8'((a >> 27) & 255)});
    end else begin
      exp_entry({2'd2, 8'(a & 255)});
      exp_entry({2'd2, 8'((a >> 8) & 7)});
      exp_entry({2'd2, 8'((a >> 11) & 255)});
      exp_entry({2'd2, 8'((a >> 19) & 255)});
      exp_entry({2'd2, 8'((a >> 27) & 1)});
    end
    exp_entry({2'd1, (op == 0) ? 8'h30 : ((op == 1) ? 8'h10 : 8'hD0)});
    np = (busy + 1 > MAXP) ? MAXP : busy + 1;
    for (int k = 0; k < np; k++) exp_entry({2'd1, 8'h70});
    if (op == 0 && busy < MAXP) exp_entry({2'd1, 8'h00});
    rq = (op == 0) ? "R2 R3 R6" : ((op == 1) ? "R4 R3 R6" : "R5 R6");
    if (poke) rq = {rq, " R9"};
    chk(ex_ok && (tr_n - t0) == ex_n, rq, "cmd/addr trace entries", tr_n - t0, ex_n);

    chk((wr_cnt - w0) == ((op == 1) ? NWORDS : 0) && wr_bad == wb0, "R4 R10",
        "program words", wr_cnt - w0, (op == 1) ? NWORDS : 0);
    chk((rd_cnt - r0) == ((op == 0 && busy < MAXP) ? NWORDS : 0) && rd_bad == rb0, "R2 R7 R10",
        "read words", rd_cnt - r0, (op == 0 && busy < MAXP) ? NWORDS : 0);
  endtask

  initial begin
    int t0, d0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #2;
    chk({dev_cle, dev_ale, dev_wr, dev_re, done, in_ready, out_valid} == 7'b0, "R1",
        "outputs in reset", {dev_cle, dev_ale, dev_wr, dev_re, done, in_ready, out_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk); #2;
    chk({dev_cle, dev_ale, dev_wr, dev_re, done, in_ready, out_valid} == 7'b0, "R1",
        "outputs after reset", {dev_cle, dev_ale, dev_wr, dev_re, done, in_ready, out_valid}, 0);

    run_op(0, 2047, 63, 3, 1'b0, 1'b0);     // R2 R3 top address
    run_op(0, 0, 0, 0, 1'b1, 1'b0);         // R7 read ignores fail bit
    run_op(1, 1234, 17, 5, 1'b0, 1'b1);     // R4 R9 request during operation
    run_op(1, 5, 5, 0, 1'b1, 1'b0);         // R7 program fail
    run_op(2, 2047, 0, 7, 1'b0, 1'b0);      // R5
    run_op(2, 1, 63, 2, 1'b1, 1'b0);        // R5 R7 erase fail
    run_op(0, 100, 3, MAXP, 1'b0, 1'b0);    // R7 read timeout
    run_op(2, 3, 3, MAXP - 1, 1'b0, 1'b0);  // R6 ready on last attempt
    run_op(1, 77, 9, MAXP, 1'b0, 1'b0);     // R7 program timeout

    // R11: unused op code
    t0 = tr_n; d0 = done_cnt;
    req = 1'b1; op_in = 2'd3; blk_in = 11'd9;
    @(negedge clk);
    req = 1'b0;
    repeat (30) @(negedge clk);
    chk(tr_n == t0, "R11", "strobes after op 3", tr_n - t0, 0);
    chk(done_cnt == d0, "R11", "done after op 3", done_cnt - d0, 0);

    for (int i = 0; i < 6; i++) begin
      run_op($urandom % 3, $urandom % 2048, $urandom % 64, $urandom % 25, 1'($urandom % 2), 1'b0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog R8 actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails + 1);
    $finish;
  end
endmodule